// File: doc/BRIEF.md
# Two-Channel Serial Port Sleep and Wake Controller

This block manages low-power operation for a serial port with two channels. It watches the status of both channels. When neither channel needs service, it puts the device into a sleep state and drops the oscillator enable so that the crystal clock stops. When an asynchronous event arrives, it restarts the oscillator and waits a fixed start-up time before declaring the device fully awake. It also raises a wake interrupt on every channel so that software learns the device has come back.

A power-save input, asserted while asleep, makes the block assert a bus-isolate enable. That enable cuts the host address, data and control lines off from the channel logic. Because the host can no longer load a transmitter in this mode, only line activity can wake the device: a start bit on a receive input, or a change on a modem-control input.

Once all pending wake interrupts have been read, and any wake caused by a modem input has been acknowledged with a modem-status read, the block drops back into sleep without host action. The per-channel wake interrupt reads back as code 0x1 in the low nibble of the interrupt status. That is the same code as "nothing pending", so software cannot tell the two apart from the code alone.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: The block moves from awake to asleep on the clock edge after all of the following hold on every channel: `ch_irq_n` bit is 1, `ch_sleep_en` bit is 1, the channel's four `ch_msr_delta` bits are all zero, and `ch_rx` is 1. If any one of these fails, the block stays awake.
- R2: `osc_en` is 0 exactly while `asleep` is 1. `bus_iso` is 1 only while `asleep` and `pwrsave` are both 1.
- R3: While asleep, a receive start bit wakes the block: `asleep` falls on the next edge. A start bit is a `ch_rx` bit that was 1 at the previous edge and is 0 now, on either channel.
- R4: While asleep, any change in a `ch_modem` bit since the previous edge wakes the block on the next edge.
- R5: While asleep with `pwrsave` 0, a `ch_tx_load` pulse wakes the block. With `pwrsave` 1 the pulse is ignored: `asleep` stays 1 and `osc_en` stays 0.
- R6: After a wake event, the block cannot re-enter sleep until OSC_START cycles of oscillator start-up have passed. With every re-entry condition already met, `asleep` rises again exactly OSC_START+1 edges after the edge at which it fell.
- R7: A wake event sets `wake_irq` on both channels. Bit i is cleared by a one-cycle `ch_isr_rd[i]` pulse. The wake interrupt code is the same as the "no interrupt" code, 0x1.
- R8: Sleep is not re-entered while any `wake_irq` bit is set. Once the last one is cleared, the block goes back to sleep on its own.
- R9: After a wake caused by a modem input on channel i, sleep is not re-entered until `ch_msr_rd[i]` has been pulsed.
- R10: Clearing any `ch_sleep_en` bit while asleep ends sleep without setting `wake_irq`. Dropping `pwrsave` while asleep removes `bus_iso` at once, and the block stays asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ch_irq_n | input | NCH | Per channel: 1 when no interrupt is pending |
| ch_sleep_en | input | NCH | Per channel sleep enable |
| ch_msr_delta | input | 4*NCH | Per channel modem-status delta bits |
| ch_rx | input | NCH | Receive line level per channel |
| ch_modem | input | 4*NCH | Modem-control input levels, four per channel |
| ch_tx_load | input | NCH | Strobe: a byte was written to the channel transmitter |
| ch_isr_rd | input | NCH | Strobe: host read of the channel interrupt status |
| ch_msr_rd | input | NCH | Strobe: host read of the channel modem status |
| pwrsave | input | 1 | Power-save request level |
| osc_en | output | 1 | Oscillator enable |
| bus_iso | output | 1 | Host bus isolation enable |
| asleep | output | 1 | Sleep state indicator |
| wake_irq | output | NCH | Per channel wake interrupt pending |

## Verification
The hardest case to reach is the start-up window. During it the block is already out of sleep but not yet awake, and the ports look the same as when fully awake. The bench reaches it by clearing both wake interrupts in the first start-up cycle while every re-entry condition holds. The moment sleep returns then shows the window length to the edge. Sleep entry is swept over all 256 combinations of the eight per-channel conditions. Every wake source is tried on each channel, with power save both off and on.

// File: rtl/uslp_pkg.sv
package uslp_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_WAKING = 2'd2
  } slp_state_t;

  localparam int unsigned MDM_W = 4;
  // Wake interrupt code shares the "none pending" value.
  localparam logic [3:0] WAKE_CODE = 4'h1;
endpackage

// File: rtl/uslp_entry_chk.sv
module uslp_entry_chk #(
  parameter int unsigned NCH = 2
) (
  input  logic [NCH-1:0]                    irq_n,
  input  logic [NCH-1:0]                    sleep_en,
  input  logic [uslp_pkg::MDM_W*NCH-1:0]    msr_delta,
  input  logic [NCH-1:0]                    rx,
  output logic                              enter_ok
);
  logic [NCH-1:0] ch_ok;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      ch_ok[i] = irq_n[i] & sleep_en[i] & rx[i]
               & ~(|msr_delta[i*uslp_pkg::MDM_W +: uslp_pkg::MDM_W]);
    end
  end

  assign enter_ok = &ch_ok;
endmodule

// File: rtl/uslp_wake_det.sv
module uslp_wake_det #(
  parameter int unsigned NCH = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NCH-1:0]                    rx,
  input  logic [uslp_pkg::MDM_W*NCH-1:0]    modem,
  input  logic [NCH-1:0]                    tx_load,
  input  logic                              pwrsave,
  output logic [NCH-1:0]                    rx_fall,
  output logic [NCH-1:0]                    mdm_chg,
  output logic [NCH-1:0]                    tx_wake
);
  localparam int unsigned MW = uslp_pkg::MDM_W * NCH;

  logic [NCH-1:0] rx_q;
  logic [MW-1:0]  mdm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '1;
      mdm_q <= '0;
    end else begin
      rx_q  <= rx;
      mdm_q <= modem;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      rx_fall[i] = rx_q[i] & ~rx[i];
      mdm_chg[i] = |(mdm_q[i*uslp_pkg::MDM_W +: uslp_pkg::MDM_W]
                     ^ modem[i*uslp_pkg::MDM_W +: uslp_pkg::MDM_W]);
      tx_wake[i] = tx_load[i] & ~pwrsave;
    end
  end
endmodule

// File: rtl/uslp_osc_timer.sv
module uslp_osc_timer #(
  parameter int unsigned OSC_START = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (OSC_START > 2) ? $clog2(OSC_START) : 1;
  localparam logic [CW-1:0] LAST = CW'(OSC_START - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start | (run & (cnt_q != LAST));
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run & (cnt_q == LAST);
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl #(
  parameter int unsigned NCH       = 2,
  parameter int unsigned OSC_START = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NCH-1:0]                 ch_irq_n,
  input  logic [NCH-1:0]                 ch_sleep_en,
  input  logic [uslp_pkg::MDM_W*NCH-1:0] ch_msr_delta,
  input  logic [NCH-1:0]                 ch_rx,
  input  logic [uslp_pkg::MDM_W*NCH-1:0] ch_modem,
  input  logic [NCH-1:0]                 ch_tx_load,
  input  logic [NCH-1:0]                 ch_isr_rd,
  input  logic [NCH-1:0]                 ch_msr_rd,
  input  logic                           pwrsave,
  output logic                           osc_en,
  output logic                           bus_iso,
  output logic                           asleep,
  output logic [NCH-1:0]                 wake_irq
);
  import uslp_pkg::*;

  slp_state_t     state_q, state_d;
  logic [NCH-1:0] wirq_q, wirq_d, hold_q, hold_d;
  logic [NCH-1:0] rx_fall, mdm_chg, tx_wake;
  logic           enter_ok, wake_any, tmr_start, tmr_done, in_sleep;

  uslp_entry_chk #(.NCH(NCH)) u_entry (
    .irq_n(ch_irq_n), .sleep_en(ch_sleep_en), .msr_delta(ch_msr_delta),
    .rx(ch_rx), .enter_ok(enter_ok)
  );

  uslp_wake_det #(.NCH(NCH)) u_wake (
    .clk(clk), .rst_n(rst_n), .rx(ch_rx), .modem(ch_modem),
    .tx_load(ch_tx_load), .pwrsave(pwrsave),
    .rx_fall(rx_fall), .mdm_chg(mdm_chg), .tx_wake(tx_wake)
  );

  uslp_osc_timer #(.OSC_START(OSC_START)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start),
    .run(state_q == ST_WAKING), .done(tmr_done)
  );

  assign in_sleep = (state_q == ST_SLEEP);
  assign wake_any = (|rx_fall) | (|mdm_chg) | (|tx_wake);

  // Next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_AWAKE:  if (enter_ok && !(|wirq_q) && !(|hold_q)) state_d = ST_SLEEP;
      ST_SLEEP:  if (wake_any || !(&ch_sleep_en))          state_d = ST_WAKING;
      ST_WAKING: if (tmr_done)                             state_d = ST_AWAKE;
      default:                                             state_d = ST_AWAKE;
    endcase
    tmr_start = in_sleep && (state_d == ST_WAKING);
  end

  // Per-channel wake interrupt and modem-wake hold
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      if (in_sleep && wake_any)  wirq_d[i] = 1'b1;
      else if (ch_isr_rd[i])     wirq_d[i] = 1'b0;
      else                       wirq_d[i] = wirq_q[i];
      if (in_sleep && mdm_chg[i]) hold_d[i] = 1'b1;
      else if (ch_msr_rd[i])      hold_d[i] = 1'b0;
      else                        hold_d[i] = hold_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      wirq_q  <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      wirq_q  <= wirq_d;
      hold_q  <= hold_d;
    end
  end

  assign osc_en   = !in_sleep;
  assign asleep   = in_sleep;
  assign bus_iso  = in_sleep & pwrsave;
  assign wake_irq = wirq_q;

  AST_ENTRY_CONDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> ($past(&ch_irq_n) && $past(&ch_sleep_en) && $past(&ch_rx))); // R1
  AST_PS_TX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && pwrsave && !(|rx_fall) && !(|mdm_chg) && (&ch_sleep_en)) |=> asleep); // R5
  AST_STARTUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |=> !asleep); // R6
  AST_WAKE_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq[0]) |-> $past(in_sleep)); // R7
  AST_NO_SLEEP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> ($past(wirq_q) == '0)); // R8
  AST_MSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> ($past(hold_q) == '0)); // R9
endmodule

// File: tb/uart_sleep_ctrl_bench.sv
module uart_sleep_ctrl_bench;
  localparam int NCH = 2;
  localparam int OSC = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0]   irq_n, sen, rx, txl, isr_rd, msr_rd, wirq;
  logic [4*NCH-1:0] delta, modem;
  logic             ps, osc_en, iso, asleep;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_sleep_ctrl #(.NCH(NCH), .OSC_START(OSC)) u_uart_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .ch_irq_n(irq_n), .ch_sleep_en(sen),
    .ch_msr_delta(delta), .ch_rx(rx), .ch_modem(modem), .ch_tx_load(txl),
    .ch_isr_rd(isr_rd), .ch_msr_rd(msr_rd), .pwrsave(ps),
    .osc_en(osc_en), .bus_iso(iso), .asleep(asleep), .wake_irq(wirq)
  );

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic base();
    irq_n = '1; sen = '1; delta = '0; rx = '1; txl = '0;
    isr_rd = '0; msr_rd = '0;
  endtask

  task automatic go_sleep(string req);
    base();
    step();
    chk(asleep == 1'b1, req, asleep, 1);
    chk(osc_en == 1'b0, "R2", osc_en, 0);
    chk(iso == ps, "R2", iso, ps);
  endtask

  // src: 0 = rx start bit, 1 = modem change, 2 = tx load
  task automatic wake_case(int src, int ch, bit p);
    ps = p;
    go_sleep("R1");
    if (src == 0)      rx[ch] = 1'b0;
    else if (src == 1) modem[ch*5] = ~modem[ch*5];
    else               txl[ch] = 1'b1;
    step();
    if (src == 2 && p) begin
      chk(asleep == 1'b1, "R5", asleep, 1);
      chk(osc_en == 1'b0, "R5", osc_en, 0);
      ps = 1'b0;
      #1 chk(iso == 1'b0, "R10", iso, 0);
      chk(asleep == 1'b1, "R10", asleep, 1);
      step();
    end
    chk(asleep == 1'b0, (src == 0) ? "R3" : (src == 1) ? "R4" : "R5", asleep, 0);
    chk(osc_en == 1'b1, "R2", osc_en, 1);
    chk(wirq == 2'b11, "R7", wirq, 3);
    rx = '1; txl = '0;
    isr_rd[0] = 1'b1; step(); isr_rd = '0;
    chk(wirq == 2'b10, "R7", wirq, 2);
    step(OSC + 2);
    chk(asleep == 1'b0, "R8", asleep, 0);
    isr_rd[1] = 1'b1; step(); isr_rd = '0;
    chk(wirq == 2'b00, "R7", wirq, 0);
    step();
    if (src == 1) begin
      chk(asleep == 1'b0, "R9", asleep, 0);
      msr_rd[ch] = 1'b1; step(); msr_rd = '0;
      step();
      chk(asleep == 1'b1, "R9", asleep, 1);
    end else begin
      chk(asleep == 1'b1, "R8", asleep, 1);
    end
    sen = '0; step(OSC + 3);
  endtask

  initial begin
    rst_n = 1'b0; ps = 1'b0; modem = '0; base(); sen = '0;
    step(2);
    rst_n = 1'b1;
    chk(asleep == 1'b0, "R2", asleep, 0);
    chk(osc_en == 1'b1, "R2", osc_en, 1);
    chk(iso == 1'b0, "R2", iso, 0);
    chk(wirq == 2'b00, "R7", wirq, 0);

    // R1: all 256 combinations of the entry conditions
    for (int p = 0; p < 256; p++) begin
      base(); sen = '0; step(OSC + 3);
      irq_n = p[1:0];
      sen   = p[3:2];
      delta = {(p[5] ? 4'h0 : 4'h8), (p[4] ? 4'h0 : 4'h2)};
      rx    = p[7:6];
      step();
      chk(asleep == (p == 255), "R1", asleep, (p == 255));
      chk(osc_en == (p != 255), "R2", osc_en, (p != 255));
    end
    // R10: leaving via sleep enable raises no wake interrupt
    sen[1] = 1'b0; step();
    chk(asleep == 1'b0, "R10", asleep, 0);
    chk(wirq == 2'b00, "R10", wirq, 0);
    sen = '0; step(OSC + 3);

    // R6: exact start-up window
    ps = 1'b0;
    go_sleep("R1");
    rx[0] = 1'b0; step();
    chk(asleep == 1'b0, "R3", asleep, 0);
    rx = '1; isr_rd = '1; step(); isr_rd = '0;
    step(OSC - 1);
    chk(asleep == 1'b0, "R6", asleep, 0);
    step();
    chk(asleep == 1'b1, "R6", asleep, 1);
    sen = '0; step(OSC + 3);

    for (int src = 0; src < 3; src++)
      for (int ch = 0; ch < NCH; ch++)
        for (int p = 0; p < 2; p++)
          wake_case(src, ch, p[0]);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule